// File: doc/BRIEF.md
# Integer Execute Unit with Condition Flags

This block is the execute stage of a small 32-bit processor. It combines the arithmetic/logic unit with the three-bit condition-flag register and the condition evaluator. When the instruction class is the integer-operation class, the function field picks one of four operations: add, subtract, bitwise AND or bitwise XOR. For every other instruction class the unit acts as a plain adder, which serves address and stack-pointer arithmetic. Its result `valE` is combinational.

The flag register holds zero, sign and overflow. It loads from the current result only on a clock edge where `setCc` is high, and the decode stage raises `setCc` only for integer operations. The condition evaluator reads the stored flags and the function field. It produces a single bit that conditional branches and conditional register moves both use, so the bit does not depend on the instruction class.

Top module: `exec_unit`

## Requirements
- R1: With `iCode` = 6 and `iFun` = 0, `valE` equals `aluA + aluB` modulo 2^32 in the same cycle.
- R2: With `iCode` = 6 and `iFun` = 1, `valE` equals `aluB - aluA` modulo 2^32.
- R3: With `iCode` = 6, `iFun` = 2 gives `aluA & aluB` and `iFun` = 3 gives `aluA ^ aluB`.
- R4: For any `iCode` other than 6, and for `iCode` = 6 with `iFun` of 4 or more, `valE` equals `aluA + aluB` whatever `iFun` is.
- R5: On a rising edge with `setCc` high, `flagZ` loads (`valE` == 0) and `flagS` loads bit 31 of `valE`. The new values are visible after that edge.
- R6: On a flag load, `flagO` is set on two's-complement overflow of an add or a subtract. It is cleared for AND and XOR.
- R7: On a rising edge with `setCc` low, all three flags keep their values.
- R8: Synchronous active-high `rst` sets `flagZ` = 1, `flagS` = 0 and `flagO` = 0.
- R9: `condOk` is combinational from the stored flags and `iFun`. With S, O and Z standing for the stored flags: 0 always gives 1; 1 gives (S^O)|Z; 2 gives S^O; 3 gives Z; 4 gives ~Z; 5 gives ~(S^O); 6 gives ~(S^O)&~Z; 7 to 15 give 0.
- R10: `condOk` does not depend on `iCode`. Branch (`iCode` = 7) and conditional move (`iCode` = 2) get the same bit for the same `iFun` and flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| iCode | input | 4 | Instruction class |
| iFun | input | 4 | Function / condition selector |
| aluA | input | 32 | Operand A |
| aluB | input | 32 | Operand B |
| setCc | input | 1 | Load enable for the flag register |
| valE | output | 32 | Combinational result |
| condOk | output | 1 | Evaluated condition bit |
| flagZ | output | 1 | Stored zero flag |
| flagS | output | 1 | Stored sign flag |
| flagO | output | 1 | Stored overflow flag |

## Verification
`valE` is due in the cycle its operands are applied. The flags are due just after the rising edge that samples `setCc`. `condOk` follows the stored flags combinationally, so it reflects a flag load from that same edge onward. The bench drives inputs on the falling edge and checks `valE` a time step later, before the next rising edge. It checks the flags and every condition code a step after that rising edge, so each check samples a settled value.

// File: rtl/exec_pkg.sv
package exec_pkg;
  typedef enum logic [1:0] {
    ALU_ADD = 2'd0,
    ALU_SUB = 2'd1,
    ALU_AND = 2'd2,
    ALU_XOR = 2'd3
  } aluOp_e;

  typedef struct packed {
    logic z;
    logic s;
    logic o;
  } flags_t;

  typedef struct packed {
    aluOp_e op;
    logic   loadFlags;
  } ctrl_t;

  localparam logic [3:0] COND_ALWAYS = 4'd0;
  localparam logic [3:0] COND_LE     = 4'd1;
  localparam logic [3:0] COND_LT     = 4'd2;
  localparam logic [3:0] COND_EQ     = 4'd3;
  localparam logic [3:0] COND_NE     = 4'd4;
  localparam logic [3:0] COND_GE     = 4'd5;
  localparam logic [3:0] COND_GT     = 4'd6;
endpackage

// File: rtl/exec_ctrl.sv
module exec_ctrl
  import exec_pkg::*;
#(
  parameter logic [3:0] OP_ICODE = 4'h6
) (
  input  logic [3:0] iCode,
  input  logic [3:0] iFun,
  input  logic       setCc,
  output ctrl_t      ctrl
);
  always_comb begin
    ctrl.loadFlags = setCc;
    ctrl.op        = ALU_ADD;
    if (iCode == OP_ICODE) begin
      unique case (iFun)
        4'd1:    ctrl.op = ALU_SUB;
        4'd2:    ctrl.op = ALU_AND;
        4'd3:    ctrl.op = ALU_XOR;
        default: ctrl.op = ALU_ADD;
      endcase
    end
  end
endmodule

// File: rtl/exec_dp.sv
module exec_dp
  import exec_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  ctrl_t            ctrl,
  input  logic [WIDTH-1:0] aluA,
  input  logic [WIDTH-1:0] aluB,
  output logic [WIDTH-1:0] valE,
  output flags_t           flags
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] sumVal;
  logic [WIDTH-1:0] diffVal;
  logic             addOvf;
  logic             subOvf;
  flags_t           nextFlags;

  always_comb begin
    sumVal  = aluA + aluB;
    diffVal = aluB - aluA;
    addOvf  = (aluA[MSB] == aluB[MSB]) && (sumVal[MSB] != aluA[MSB]);
    subOvf  = (aluA[MSB] != aluB[MSB]) && (diffVal[MSB] != aluB[MSB]);
    unique case (ctrl.op)
      ALU_SUB: valE = diffVal;
      ALU_AND: valE = aluA & aluB;
      ALU_XOR: valE = aluA ^ aluB;
      default: valE = sumVal;
    endcase
  end

  always_comb begin
    nextFlags.z = (valE == '0);
    nextFlags.s = valE[MSB];
    unique case (ctrl.op)
      ALU_ADD: nextFlags.o = addOvf;
      ALU_SUB: nextFlags.o = subOvf;
      default: nextFlags.o = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '{z: 1'b1, s: 1'b0, o: 1'b0};
    end else if (ctrl.loadFlags) begin
      flags <= nextFlags;
    end
  end
endmodule

// File: rtl/exec_cond.sv
module exec_cond
  import exec_pkg::*;
(
  input  flags_t     flags,
  input  logic [3:0] iFun,
  output logic       condOk
);
  logic lessThan;

  always_comb begin
    lessThan = flags.s ^ flags.o;
    unique case (iFun)
      COND_ALWAYS: condOk = 1'b1;
      COND_LE:     condOk = lessThan | flags.z;
      COND_LT:     condOk = lessThan;
      COND_EQ:     condOk = flags.z;
      COND_NE:     condOk = ~flags.z;
      COND_GE:     condOk = ~lessThan;
      COND_GT:     condOk = ~lessThan & ~flags.z;
      default:     condOk = 1'b0;
    endcase
  end
endmodule

// File: rtl/exec_unit.sv
module exec_unit
  import exec_pkg::*;
#(
  parameter int         WIDTH    = 32,
  parameter logic [3:0] OP_ICODE = 4'h6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [3:0]       iCode,
  input  logic [3:0]       iFun,
  input  logic [WIDTH-1:0] aluA,
  input  logic [WIDTH-1:0] aluB,
  input  logic             setCc,
  output logic [WIDTH-1:0] valE,
  output logic             condOk,
  output logic             flagZ,
  output logic             flagS,
  output logic             flagO
);
  ctrl_t  ctrl;
  flags_t flags;

  exec_ctrl #(.OP_ICODE(OP_ICODE)) uCtrl (
    .iCode (iCode),
    .iFun  (iFun),
    .setCc (setCc),
    .ctrl  (ctrl)
  );

  exec_dp #(.WIDTH(WIDTH)) uDp (
    .clk   (clk),
    .rst   (rst),
    .ctrl  (ctrl),
    .aluA  (aluA),
    .aluB  (aluB),
    .valE  (valE),
    .flags (flags)
  );

  exec_cond uCond (
    .flags  (flags),
    .iFun   (iFun),
    .condOk (condOk)
  );

  assign flagZ = flags.z;
  assign flagS = flags.s;
  assign flagO = flags.o;
endmodule

// File: rtl/exec_unit_chk.sv
module exec_unit_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst,
  input logic [3:0]       iCode,
  input logic [3:0]       iFun,
  input logic [WIDTH-1:0] aluA,
  input logic [WIDTH-1:0] aluB,
  input logic             setCc,
  input logic [WIDTH-1:0] valE,
  input logic             condOk,
  input logic             flagZ,
  input logic             flagS,
  input logic             flagO
);
  logic [WIDTH-1:0] addRef;
  assign addRef = aluA + aluB;

  assert_add_R1: assert property (@(posedge clk) disable iff (rst)
    (iCode == 4'd6 && iFun == 4'd0) |-> (valE == addRef));

  assert_adder_default_R4: assert property (@(posedge clk) disable iff (rst)
    (iCode != 4'd6) |-> (valE == addRef));

  assert_zero_load_R5: assert property (@(posedge clk) disable iff (rst)
    setCc |=> (flagZ == ($past(valE) == '0)) && (flagS == $past(valE[WIDTH-1])));

  assert_logic_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
    (setCc && iCode == 4'd6 && (iFun == 4'd2 || iFun == 4'd3)) |=> !flagO);

  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(setCc)) |-> ($stable(flagZ) && $stable(flagS) && $stable(flagO)));

  assert_reset_R8: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (flagZ && !flagS && !flagO));

  assert_cond_always_R9: assert property (@(posedge clk) disable iff (rst)
    (iFun == 4'd0) |-> condOk);

  assert_cond_eq_R10: assert property (@(posedge clk) disable iff (rst)
    (iFun == 4'd3) |-> (condOk == flagZ));
endmodule

bind exec_unit exec_unit_chk #(.WIDTH(WIDTH)) uChk (
  .clk    (clk),
  .rst    (rst),
  .iCode  (iCode),
  .iFun   (iFun),
  .aluA   (aluA),
  .aluB   (aluB),
  .setCc  (setCc),
  .valE   (valE),
  .condOk (condOk),
  .flagZ  (flagZ),
  .flagS  (flagS),
  .flagO  (flagO)
);

// File: tb/tb_exec_unit.sv
module tb_exec_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 12;

  typedef struct packed {
    logic [3:0]  fn;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] res;
    logic        z;
    logic        s;
    logic        o;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{4'd0, 32'h0000_0005, 32'h0000_0007, 32'h0000_000C, 1'b0, 1'b0, 1'b0},
    '{4'd0, 32'h7FFF_FFFF, 32'h0000_0001, 32'h8000_0000, 1'b0, 1'b1, 1'b1},
    '{4'd0, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0000, 1'b1, 1'b0, 1'b0},
    '{4'd1, 32'h0000_0003, 32'h0000_000A, 32'h0000_0007, 1'b0, 1'b0, 1'b0},
    '{4'd1, 32'h0000_000A, 32'h0000_0003, 32'hFFFF_FFF9, 1'b0, 1'b1, 1'b0},
    '{4'd1, 32'h0000_0001, 32'h8000_0000, 32'h7FFF_FFFF, 1'b0, 1'b0, 1'b1},
    '{4'd1, 32'h0000_0005, 32'h0000_0005, 32'h0000_0000, 1'b1, 1'b0, 1'b0},
    '{4'd2, 32'hF0F0_F0F0, 32'h0F0F_0F0F, 32'h0000_0000, 1'b1, 1'b0, 1'b0},
    '{4'd2, 32'hFFFF_0000, 32'h8000_FFFF, 32'h8000_0000, 1'b0, 1'b1, 1'b0},
    '{4'd3, 32'hAAAA_AAAA, 32'h5555_5555, 32'hFFFF_FFFF, 1'b0, 1'b1, 1'b0},
    '{4'd3, 32'h1234_5678, 32'h1234_5678, 32'h0000_0000, 1'b1, 1'b0, 1'b0},
    '{4'd0, 32'h8000_0000, 32'h8000_0000, 32'h0000_0000, 1'b1, 1'b0, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  iCode = 4'd0;
  logic [3:0]  iFun = 4'd0;
  logic [31:0] aluA = '0;
  logic [31:0] aluB = '0;
  logic        setCc = 1'b0;
  logic [31:0] valE;
  logic        condOk;
  logic        flagZ, flagS, flagO;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  exec_unit dut (
    .clk(clk), .rst(rst), .iCode(iCode), .iFun(iFun), .aluA(aluA), .aluB(aluB),
    .setCc(setCc), .valE(valE), .condOk(condOk), .flagZ(flagZ), .flagS(flagS),
    .flagO(flagO)
  );

  function automatic logic expCond(input logic [3:0] f, input logic z, input logic s,
                                   input logic o);
    case (f)
      4'd0: return 1'b1;
      4'd1: return (s ^ o) | z;
      4'd2: return s ^ o;
      4'd3: return z;
      4'd4: return ~z;
      4'd5: return ~(s ^ o);
      4'd6: return ~(s ^ o) & ~z;
      default: return 1'b0;
    endcase
  endfunction

  task automatic checkVal(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic checkFlags(input string req, input logic z, input logic s, input logic o);
    checks++;
    if ({flagZ, flagS, flagO} !== {z, s, o}) begin
      errors++;
      $display("FAIL %s: actual ZSO=%b%b%b expected=%b%b%b", req, flagZ, flagS, flagO, z, s, o);
    end
  endtask

  task automatic checkAllConds(input logic z, input logic s, input logic o);
    setCc = 1'b0;
    for (int f = 0; f < 16; f++) begin
      iFun  = 4'(f);
      iCode = (f % 2 == 0) ? 4'd2 : 4'd7;  // R10: moves and branches alternate
      #1;
      checks++;
      if (condOk !== expCond(4'(f), z, s, o)) begin
        errors++;
        $display("FAIL R9/R10: ifun=%0d icode=%0d actual=%b expected=%b", f, iCode, condOk,
                 expCond(4'(f), z, s, o));
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    checkFlags("R8 reset", 1'b1, 1'b0, 1'b0);
    checkAllConds(1'b1, 1'b0, 1'b0);

    // Table walk: R1 R2 R3 results, R5 R6 flag loads, R9 conditions
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      iCode = 4'd6;
      iFun  = VECS[i].fn;
      aluA  = VECS[i].a;
      aluB  = VECS[i].b;
      setCc = 1'b1;
      #1;
      checkVal("R1/R2/R3 valE", valE, VECS[i].res);
      @(posedge clk);
      #1;
      checkFlags("R5/R6 flags", VECS[i].z, VECS[i].s, VECS[i].o);
      checkAllConds(VECS[i].z, VECS[i].s, VECS[i].o);
    end

    // R4: other instruction classes add regardless of ifun
    @(negedge clk);
    iCode = 4'd4; iFun = 4'd1; aluA = 32'h10; aluB = 32'h20; setCc = 1'b0;
    #1;
    checkVal("R4 adder other icode", valE, 32'h30);
    iCode = 4'd6; iFun = 4'd9;
    #1;
    checkVal("R4 adder op ifun>=4", valE, 32'h30);

    // R7: flags hold with setCc low (last vector left Z=1 S=0 O=1)
    iCode = 4'd6; iFun = 4'd0; aluA = 32'h7FFF_FFFF; aluB = 32'h7FFF_FFFF; setCc = 1'b0;
    @(posedge clk);
    #1;
    checkFlags("R7 hold", 1'b1, 1'b0, 1'b1);

    // Load a nonzero set then reset mid-run (R8)
    @(negedge clk);
    setCc = 1'b1;
    @(posedge clk);
    #1;
    checkFlags("R6 add overflow positive", 1'b0, 1'b1, 1'b1);
    @(negedge clk);
    setCc = 1'b0;
    rst = 1'b1;
    @(posedge clk);
    #1;
    checkFlags("R8 mid-run reset", 1'b1, 1'b0, 1'b0);
    @(negedge clk);
    rst = 1'b0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule